// File: doc/BRIEF.md
# Memory Access Alignment and Fault Guard

This block sits between a hart's fetch/load/store path and its memory port. Each request carries a kind (fetch, load or store), a byte address, a size code and write data. The guard checks alignment before anything reaches memory. A misaligned request is never issued. Instead, the block raises an exception toward the trap unit with a cause code and latches the offending address. An aligned request is forwarded unchanged over a valid/ready handshake. When the memory response arrives, a good response goes straight back to the hart. An error response becomes an access-fault exception.

Fetch alignment follows a configuration input that says whether compressed instructions are enabled. Load and store alignment follows the access length. While an exception is pending, the guard accepts no new request. The trap unit acknowledges the exception, which clears both the exception word and the fault address.

The controller has four states:
- `ST_IDLE`: ready for a request.
- `ST_ISSUE`: the memory request is held until memory accepts it.
- `ST_AWAIT`: waiting for the response.
- `ST_TRAP`: the exception is presented.

The transitions are:
- `IDLE→TRAP` on a misaligned request.
- `IDLE→ISSUE` on an aligned request.
- `ISSUE→AWAIT` on `mem_ready`.
- `AWAIT→IDLE` on a good response.
- `AWAIT→TRAP` on an error response.
- `TRAP→IDLE` on `trap_ack`.

Top module: `mem_access_guard`

## Requirements
- R1: A fetch (kind code 0) needs 2-byte alignment when `rvc_on` is 1 and 4-byte alignment when it is 0. A fetch ignores the size code for this test. A misaligned fetch raises cause 4.
- R2: A load (kind 1) or store (kind 2) needs alignment equal to its length of 2^size bytes (size code 0=1 B, 1=2 B, 2=4 B, 3=8 B). The test is a nonzero value of address AND (length−1), so size code 0 never faults for alignment.
- R3: A misaligned load raises cause 4 and a misaligned store raises cause 6. In neither case is `mem_valid` asserted for that request.
- R4: An error response (`mem_rsp_err`=1 with `mem_rsp_valid`) raises cause 5 for a load, 7 for a store and 1 for a fetch. No `rsp_valid` is given for it.
- R5: `trap_word` is 0 when no exception is pending. While one is pending, bit 31 is 1, bits 19:16 hold the cause and all other bits are 0. It stays unchanged until `trap_ack`.
- R6: `fault_addr` holds the offending request address from the cycle the exception appears. It returns to 0 in the cycle after `trap_ack`.
- R7: An aligned request appears on `mem_kind`, `mem_size`, `mem_addr` and `mem_wdata` unchanged, with `mem_valid` held until `mem_ready`.
- R8: A good response produces `rsp_valid`=1 with `rsp_rdata` equal to `mem_rsp_rdata` in the same cycle, and raises no exception.
- R9: After reset `req_ready`=1, `mem_valid`=0, `trap_word`=0 and `fault_addr`=0. `req_ready` is 0 in every state but `ST_IDLE`, so a request offered while an exception is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rvc_on | input | 1 | Compressed instructions enabled (fetch alignment 2 instead of 4) |
| req_valid | input | 1 | Hart request valid |
| req_ready | output | 1 | Guard can accept a request |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_size | input | SZW | log2 of access length in bytes |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| mem_valid | output | 1 | Request to memory valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_kind | output | 2 | Forwarded kind |
| mem_size | output | SZW | Forwarded size code |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | DW | Forwarded store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response is an error |
| mem_rsp_rdata | input | DW | Memory read data |
| rsp_valid | output | 1 | Good response to the hart |
| rsp_rdata | output | DW | Read data to the hart |
| trap_word | output | 32 | Exception request: bit 31 valid, cause at bits 19:16 |
| trap_ack | input | 1 | Trap unit has consumed the exception |
| fault_addr | output | AW | Latched faulting address |

## Verification
The bench builds the guard with AW=32, DW=32 and SZW=2. SZW=2 puts 1-, 2-, 4- and 8-byte lengths within reach, so alignment masks of zero to three bits are all tested. With a 32-bit address, the bench can probe the top of the address space, where a 2-byte store at the last byte must fault and never wrap into a memory request. It also covers both settings of `rvc_on` on the same addresses and a memory stall on the forwarded request.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2,
        ST_TRAP  = 2'd3
    } guard_state_e;

    localparam int CAUSE_W = 4;
    localparam int TRAP_W  = 32;
    localparam int CAUSE_LSB = 16;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_FAULT = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISAL    = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISAL    = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT    = 4'd7;

    // Width of the low address slice that any alignment test can inspect.
    function automatic int low_bits(input int szw);
        int mw;
        mw = (1 << szw) - 1;
        return (mw < 2) ? 2 : mw;
    endfunction

    function automatic logic [TRAP_W-1:0] pack_trap(input logic [CAUSE_W-1:0] cause);
        logic [TRAP_W-1:0] w;
        w = '0;
        w[TRAP_W-1] = 1'b1;
        w[CAUSE_LSB +: CAUSE_W] = cause;
        return w;
    endfunction

endpackage

// File: rtl/acc_align_chk.sv
module acc_align_chk
    import acc_guard_pkg::*;
#(
    parameter int SZW = 2
) (
    input  acc_kind_e                     kind,
    input  logic [SZW-1:0]                size,
    input  logic                          rvc_on,
    input  logic [low_bits(SZW)-1:0]      addr_lo,
    output logic                          misaligned,
    output logic [CAUSE_W-1:0]            cause
);
    localparam int LW = low_bits(SZW);

    logic [LW-1:0] size_mask;
    logic [LW-1:0] fetch_mask;
    logic [LW-1:0] use_mask;

    // Mask bit i is set when the access length exceeds 2^i bytes.
    for (genvar i = 0; i < LW; i++) begin : g_mask
        assign size_mask[i] = (int'(size) > i);
    end

    always_comb begin
        fetch_mask    = '0;
        fetch_mask[0] = 1'b1;
        fetch_mask[1] = ~rvc_on;
    end

    always_comb begin
        use_mask   = (kind == ACC_FETCH) ? fetch_mask : size_mask;
        misaligned = |(addr_lo & use_mask);
        cause      = (kind == ACC_STORE) ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
    end

    // R2
    always_comb begin
        if (kind != ACC_FETCH && size == '0) begin
            byte_never_misal_chk: assert (!misaligned);
        end
    end

endmodule

// File: rtl/acc_fault_reg.sv
module acc_fault_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] cap_addr,
    input  logic          clear,
    output logic [AW-1:0] fault_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (capture) begin
            fault_addr <= cap_addr;
        end else if (clear) begin
            fault_addr <= '0;
        end
    end

    // R6
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !capture) |=> (fault_addr == '0));

    // R6
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (fault_addr == $past(cap_addr)));

endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
    import acc_guard_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SZW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rvc_on,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [SZW-1:0]     req_size,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [1:0]         mem_kind,
    output logic [SZW-1:0]     mem_size,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [DW-1:0]      mem_rsp_rdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic [TRAP_W-1:0]  trap_word,
    input  logic               trap_ack,
    output logic [AW-1:0]      fault_addr
);
    localparam int LW = low_bits(SZW);

    guard_state_e state_q, state_d;

    acc_kind_e          kind_q;
    logic [SZW-1:0]     size_q;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;
    logic [CAUSE_W-1:0] cause_q, cause_d;

    logic               accept;
    logic               mis;
    logic [CAUSE_W-1:0] mis_cause;
    logic               rsp_fault;
    logic [CAUSE_W-1:0] rsp_cause;
    logic               cap_en;
    logic [AW-1:0]      cap_addr;
    logic               clr_en;

    acc_align_chk #(.SZW(SZW)) u_align (
        .kind       (acc_kind_e'(req_kind)),
        .size       (req_size),
        .rvc_on     (rvc_on),
        .addr_lo    (req_addr[LW-1:0]),
        .misaligned (mis),
        .cause      (mis_cause)
    );

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign rsp_fault = (state_q == ST_AWAIT) && mem_rsp_valid && mem_rsp_err;

    always_comb begin
        unique case (kind_q)
            ACC_FETCH: rsp_cause = CAUSE_FETCH_FAULT;
            ACC_STORE: rsp_cause = CAUSE_ST_FAULT;
            default:   rsp_cause = CAUSE_LD_FAULT;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (mis) begin
                        state_d = ST_TRAP;
                        cause_d = mis_cause;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_ready) state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        state_d = ST_TRAP;
                        cause_d = rsp_cause;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_TRAP: begin
                if (trap_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Request holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= ACC_FETCH;
            size_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= acc_kind_e'(req_kind);
            size_q  <= req_size;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign cap_en   = (accept && mis) || rsp_fault;
    assign cap_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign clr_en   = (state_q == ST_TRAP) && trap_ack;

    acc_fault_reg #(.AW(AW)) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (cap_en),
        .cap_addr   (cap_addr),
        .clear      (clr_en),
        .fault_addr (fault_addr)
    );

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        rsp_valid = 1'b0;
        trap_word = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: mem_valid = 1'b1;
            ST_AWAIT: rsp_valid = mem_rsp_valid && !mem_rsp_err;
            ST_TRAP:  trap_word = pack_trap(cause_q);
            default:  req_ready = 1'b0;
        endcase
        mem_kind  = kind_q;
        mem_size  = size_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        rsp_rdata = mem_rsp_rdata;
    end

    // R3
    misal_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && mis) |=> (!mem_valid && trap_word[TRAP_W-1]));

    // R7
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    // R5
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_word[TRAP_W-1] && !trap_ack) |=> $stable(trap_word));

    // R8
    rsp_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !trap_word[TRAP_W-1]);

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || trap_word[TRAP_W-1]) |-> !req_ready);

endmodule

// File: tb/test_mem_access_guard.sv
module test_mem_access_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SZW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rvc_on = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0;
    logic [SZW-1:0] req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic mem_valid;
    logic mem_ready = 1'b0;
    logic [1:0] mem_kind;
    logic [SZW-1:0] mem_size;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_err = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [31:0] trap_word;
    logic trap_ack = 1'b0;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_access_guard #(.AW(AW), .DW(DW), .SZW(SZW)) i_mem_access_guard (
        .clk(clk), .rst_n(rst_n), .rvc_on(rvc_on),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .trap_word(trap_word), .trap_ack(trap_ack), .fault_addr(fault_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  size;
        logic        rvc;
        logic        err;
        logic [31:0] addr;
        logic        trap;
        logic [3:0]  cause;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd2, 1'b1, 1'b0, 32'h0000_1002, 1'b0, 4'd0, 4'd1}, // R1 fetch 2-aligned, rvc on
        '{2'd0, 2'd2, 1'b0, 1'b0, 32'h0000_1002, 1'b1, 4'd4, 4'd1}, // R1 same address, rvc off
        '{2'd0, 2'd0, 1'b1, 1'b0, 32'h0000_1001, 1'b1, 4'd4, 4'd1}, // R1 odd fetch, size ignored
        '{2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1004, 1'b0, 4'd0, 4'd1}, // R1 4-aligned fetch
        '{2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_2003, 1'b0, 4'd0, 4'd2}, // R2 byte load anywhere
        '{2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_2001, 1'b1, 4'd4, 4'd2}, // R2 half load odd
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_2002, 1'b1, 4'd4, 4'd2}, // R2 word load at 2
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_2008, 1'b0, 4'd0, 4'd2}, // R2 word load aligned
        '{2'd2, 2'd1, 1'b0, 1'b0, 32'h0000_3006, 1'b0, 4'd0, 4'd2}, // R2 half store aligned
        '{2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_3006, 1'b1, 4'd6, 4'd3}, // R3 word store misaligned
        '{2'd2, 2'd0, 1'b0, 1'b0, 32'h0000_3007, 1'b0, 4'd0, 4'd2}, // R2 byte store
        '{2'd1, 2'd3, 1'b0, 1'b0, 32'h0000_4004, 1'b1, 4'd4, 4'd2}, // R2 8-byte load at 4
        '{2'd1, 2'd3, 1'b0, 1'b0, 32'h0000_4008, 1'b0, 4'd0, 4'd2}, // R2 8-byte load aligned
        '{2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_5000, 1'b1, 4'd5, 4'd4}, // R4 load bus error
        '{2'd2, 2'd2, 1'b0, 1'b1, 32'h0000_5004, 1'b1, 4'd7, 4'd4}, // R4 store bus error
        '{2'd0, 2'd2, 1'b0, 1'b1, 32'h0000_5008, 1'b1, 4'd1, 4'd4}, // R4 fetch bus error
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFC, 1'b0, 4'd0, 4'd7}, // R7 top word load
        '{2'd2, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'd6, 4'd3}  // R3 last-byte half store
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] tw(input logic [3:0] c);
        return 32'h8000_0000 | (32'(c) << 16);
    endfunction

    task automatic ack_trap(input logic [3:0] c, input logic [31:0] a, input string rq);
        chk({rq, " trap_word"}, 64'(trap_word), 64'(tw(c)));
        chk("R6 fault_addr", 64'(fault_addr), 64'(a));
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        chk("R5 trap cleared", 64'(trap_word), 64'd0);
        chk("R6 fault cleared", 64'(fault_addr), 64'd0);
        chk("R9 ready after ack", 64'(req_ready), 64'd1);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string rq;
        logic [31:0] wd;
        logic [31:0] rd;
        rq = $sformatf("R%0d v%0d", v.rq, idx);
        wd = 32'hA500_0000 | 32'(idx);
        rd = 32'h5A00_0000 | 32'(idx);
        @(negedge clk);
        rvc_on = v.rvc;
        req_kind = v.kind;
        req_size = v.size;
        req_addr = v.addr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.trap && !v.err) begin
            chk({rq, " no issue"}, 64'(mem_valid), 64'd0);
            ack_trap(v.cause, v.addr, rq);
        end else begin
            chk({rq, " mem_valid"}, 64'(mem_valid), 64'd1);
            chk({rq, " mem_addr"}, 64'(mem_addr), 64'(v.addr));
            chk("R7 fields", 64'({mem_kind, mem_size, mem_wdata}), 64'({v.kind, v.size, wd}));
            chk("R9 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            chk("R7 held in stall", 64'({mem_valid, mem_addr}), 64'({1'b1, v.addr}));
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            chk("R7 dropped after ready", 64'(mem_valid), 64'd0);
            mem_rsp_valid = 1'b1;
            mem_rsp_err = v.err;
            mem_rsp_rdata = rd;
            #1;
            chk({rq, " rsp_valid"}, 64'(rsp_valid), 64'(!v.err));
            if (!v.err) chk("R8 rdata", 64'(rsp_rdata), 64'(rd));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
            if (v.err) begin
                ack_trap(v.cause, v.addr, rq);
            end else begin
                chk("R8 no trap", 64'(trap_word), 64'd0);
                chk("R9 idle again", 64'(req_ready), 64'd1);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset ready", 64'(req_ready), 64'd1);
        chk("R9 reset mem_valid", 64'(mem_valid), 64'd0);
        chk("R9 reset trap", 64'(trap_word), 64'd0);
        chk("R9 reset fault", 64'(fault_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R9 request offered during a pending exception is ignored
        req_kind = 2'd2; req_size = 2'd2; req_addr = 32'h0000_6002; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_7000; req_size = 2'd2; req_kind = 2'd1;
        @(negedge clk);
        chk("R9 ignored while trapped", 64'({mem_valid, req_ready}), 64'd0);
        chk("R5 unchanged", 64'(trap_word), 64'(tw(4'd6)));
        chk("R6 unchanged", 64'(fault_addr), 64'h6002);
        req_valid = 1'b0;
        ack_trap(4'd6, 32'h0000_6002, "R5");

        // R1 rvc toggled on the same fetch address 0x...06
        run_vec('{2'd0, 2'd2, 1'b1, 1'b0, 32'h0000_0006, 1'b0, 4'd0, 4'd1}, 100);
        run_vec('{2'd0, 2'd2, 1'b0, 1'b0, 32'h0000_0006, 1'b1, 4'd4, 4'd1}, 101);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule